// File: doc/BRIEF.md
# Masked Interrupt Aggregator

The block gathers level interrupt requests from six sub-units of a peripheral card (a serial flash controller, two two-wire bus controllers, two stream DMA channels and a common-interface slot controller) and drives one level interrupt line toward the host. Each request appears as one bit in a 16-bit pending register. Software reads that register to see every request, masked or not. It chooses which requests may reach the host through a per-source mask. The mask is never written whole: one register sets the mask bits written as one, and another clears them.

A global gate register sits above the mask. Its bit 7 passes the line to the host. An interrupt service routine typically clears the gate on entry and sets it again on exit. While the gate is closed, a separate gate-status register still shows in bit 7 whether any enabled request is pending, so the routine can tell whether the interrupt is its own. To speed up dispatch, a pick register gives the index of the highest-priority pending enabled source. Priority is fixed: bit 0 is served first and bit 5 last.

Register map (3-bit address): 0 pending, 1 mask readback, 2 mask set, 3 mask clear, 4 gate, 5 gate status, 6 pick. Source bits: 0 serial flash, 1 bus controller 0, 2 bus controller 1, 3 DMA channel 1, 4 DMA channel 2, 5 slot controller.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted and after it, the mask is all zero, the gate is closed, pending reads zero and `host_irq` is low.
- R2: Address 0 reads the source levels sampled at the previous clock edge in bits 5:0, whatever the mask. Each bit clears as soon as its source drops. Bits 15:6 read zero.
- R3: A write to address 2 sets every mask bit whose data bit is one and leaves the others unchanged. Address 1 reads the mask in bits 5:0 from the next cycle.
- R4: A write to address 3 clears every mask bit whose data bit is one and leaves the others unchanged. Writing 0xFFFF there masks every source.
- R5: Mask bits 15:6 do not exist. Writing ones to them through address 2 has no effect, and they read zero.
- R6: A write to address 4 loads the gate from data bit 7 and ignores all other data bits. Writing 0x00 closes the gate, and writing 0x80 opens it. Address 4 reads the gate in bit 7 and zero elsewhere.
- R7: `host_irq` is high exactly when the gate is open and at least one pending source is unmasked, both as registered state.
- R8: Address 5 reads, in bit 7, whether any pending source is unmasked, whether the gate is open or closed. All other bits read zero.
- R9: Address 6 reads bit 15 = 1 and bits 2:0 = the lowest bit index among pending unmasked sources, or all zero when there is none. The gate does not affect this register.
- R10: Writes to addresses 0, 1, 5, 6 and 7 change no state. Addresses 2, 3 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 6 | Level requests, one per sub-unit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data, combinational from rd_addr |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The hardest condition to reach is a closed gate together with pending unmasked sources of mixed priority, followed by a change to the mask in the same cycle that a source drops. In that state the gate-status and pick registers must stay live while the host line stays quiet. The stimulus opens the gate, sets a sparse mask, closes the gate through a value whose other bits are all ones, and then steps sources and mask writes one cycle apart. A long random phase follows. It rotates the read address every cycle so that each register is compared with the model in every combination of state.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int ADDR_W   = 3;
   localparam int GATE_BIT = 7;

   typedef enum logic [ADDR_W-1:0] {
      SEL_PEND  = 3'd0,
      SEL_MASK  = 3'd1,
      SEL_MSET  = 3'd2,
      SEL_MCLR  = 3'd3,
      SEL_GATE  = 3'd4,
      SEL_GSTAT = 3'd5,
      SEL_PICK  = 3'd6,
      SEL_NONE  = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/irq_level_capture.sv
module irq_level_capture #(
   parameter int N          = 6,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_in,
   output logic [N-1:0] level_out
);
   generate
      if (REGISTERED) begin : g_flop
         logic [N-1:0] level_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level_q <= '0;
            else        level_q <= req_in;
         end
         assign level_out = level_q;

         // R2: the pending image follows the request levels one edge later
         assert_pend_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (level_out == $past(req_in)));
      end else begin : g_pass
         assign level_out = req_in;
      end
   endgenerate
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int           N        = 6,
   parameter logic [N-1:0] MASK_RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [N-1:0] bits,
   output logic [N-1:0] mask_out
);
   logic [N-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= MASK_RST;
      else if (set_we) mask_q <= mask_q | bits;
      else if (clr_we) mask_q <= mask_q & ~bits;
   end
   assign mask_out = mask_q;

   assert_set_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((mask_out & $past(bits)) == $past(bits)));

   assert_clr_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((mask_out & $past(bits)) == '0));

   assert_mask_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_out));
endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
   parameter int N     = 6,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] pick_idx,
   output logic             pick_valid
);
   always_comb begin
      pick_idx   = '0;
      pick_valid = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            pick_idx   = i[IDX_W-1:0];
            pick_valid = 1'b1;
         end
      end
   end

   // R9: the chosen source is pending and no lower index is pending
   assert_pick_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> req[pick_idx]);

   assert_pick_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> ((req & ((N'(1) << pick_idx) - N'(1))) == '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int                  NUM_SRC      = 6,
   parameter int                  REG_W        = 16,
   parameter bit                  CAPTURE_FLOP = 1'b1,
   parameter logic [NUM_SRC-1:0]  MASK_RST     = '0
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_SRC-1:0]               src_req,
   input  logic                             wr_en,
   input  logic [irq_agg_pkg::ADDR_W-1:0]   wr_addr,
   input  logic [REG_W-1:0]                 wr_data,
   input  logic [irq_agg_pkg::ADDR_W-1:0]   rd_addr,
   output logic [REG_W-1:0]                 rd_data,
   output logic                             host_irq
);
   import irq_agg_pkg::*;

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   generate
      if (NUM_SRC < 2 || NUM_SRC > REG_W - 1) begin : g_bad_src
         $error("irq_aggregator: NUM_SRC must lie in 2..REG_W-1");
      end
      if (REG_W <= GATE_BIT || IDX_W >= REG_W - 1) begin : g_bad_width
         $error("irq_aggregator: REG_W too narrow for gate bit or pick index");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] live;
   logic               any_live;
   logic               gate_q;
   logic [IDX_W-1:0]   pick_idx;
   logic               pick_valid;
   logic               set_we;
   logic               clr_we;
   logic               gate_we;
   logic               unused_wr_bits;

   assign set_we  = wr_en && (wr_addr == SEL_MSET);
   assign clr_we  = wr_en && (wr_addr == SEL_MCLR);
   assign gate_we = wr_en && (wr_addr == SEL_GATE);
   assign unused_wr_bits = ^wr_data;

   irq_level_capture #(.N(NUM_SRC), .REGISTERED(CAPTURE_FLOP)) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_in    (src_req),
      .level_out (pend)
   );

   irq_mask_bank #(.N(NUM_SRC), .MASK_RST(MASK_RST)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we   (set_we),
      .clr_we   (clr_we),
      .bits     (wr_data[NUM_SRC-1:0]),
      .mask_out (mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gate_q <= 1'b0;
      else if (gate_we) gate_q <= wr_data[GATE_BIT];
   end

   assign live     = pend & mask;
   assign any_live = |live;
   assign host_irq = gate_q & any_live;

   irq_first_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (live),
      .pick_idx   (pick_idx),
      .pick_valid (pick_valid)
   );

   always_comb begin
      rd_data = '0;
      case (reg_sel_e'(rd_addr))
         SEL_PEND:  rd_data[NUM_SRC-1:0] = pend;
         SEL_MASK:  rd_data[NUM_SRC-1:0] = mask;
         SEL_GATE:  rd_data[GATE_BIT]    = gate_q;
         SEL_GSTAT: rd_data[GATE_BIT]    = any_live;
         SEL_PICK: begin
            rd_data[REG_W-1]   = pick_valid;
            rd_data[IDX_W-1:0] = pick_idx;
         end
         default:   rd_data = '0;
      endcase
   end

   // R6: closing the gate silences the host line on the next cycle
   assert_gate_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_we && !wr_data[GATE_BIT]) |=> !host_irq);

   // R10: writes to read-only addresses leave mask and gate untouched
   assert_ro_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !set_we && !clr_we && !gate_we) |=> ($stable(mask) && $stable(gate_q)));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  src_req = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        host_irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_aggregator uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .host_irq(host_irq)
   );

   // behavioural reference state
   bit [5:0] m_pend = '0;
   bit [5:0] m_mask = '0;
   bit       m_gate = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pend <= '0; m_mask <= '0; m_gate <= 1'b0;
      end else begin
         m_pend <= src_req;
         if (wr_en) begin
            if (wr_addr == 3'd2) m_mask <= m_mask | wr_data[5:0];
            if (wr_addr == 3'd3) m_mask <= m_mask & ~wr_data[5:0];
            if (wr_addr == 3'd4) m_gate <= wr_data[7];
         end
      end
   end

   function automatic bit [15:0] exp_read(input bit [2:0] a);
      bit [15:0] r = '0;
      bit [5:0]  live = m_pend & m_mask;
      case (a)
         3'd0: r[5:0] = m_pend;
         3'd1: r[5:0] = m_mask;
         3'd4: r[7] = m_gate;
         3'd5: r[7] = (live != 0);
         3'd6: begin
            for (int i = 5; i >= 0; i--)
               if (live[i]) begin r[15] = 1'b1; r[2:0] = 3'(i); end
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input bit [2:0] a);
      case (a)
         3'd0: return "R2";
         3'd1: return "R3,R4,R5";
         3'd4: return "R6";
         3'd5: return "R8";
         3'd6: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
      end
   endtask

   // compare at the falling edge, then apply the next inputs
   task automatic step(input bit [5:0] s, input bit we, input bit [2:0] wa, input bit [15:0] wd);
      @(negedge clk);
      check("R7", {15'b0, host_irq}, {15'b0, m_gate && ((m_pend & m_mask) != 0)});
      check(tag_of(rd_addr), rd_data, exp_read(rd_addr));
      src_req = s; wr_en = we; wr_addr = wa; wr_data = wd;
      rd_addr = rd_addr + 3'd1;
   endtask

   task automatic idle(input bit [5:0] s, input int n);
      for (int k = 0; k < n; k++) step(s, 1'b0, 3'd0, 16'h0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: state during reset
      src_req = 6'h3F;
      for (int a = 0; a < 8; a++) begin
         rd_addr = 3'(a); #1;
         check("R1", rd_data, 16'h0);
      end
      check("R1", {15'b0, host_irq}, 16'h0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1; src_req = '0; rd_addr = '0;
      idle(6'h00, 8);

      // R2: raw levels visible while masked; line stays low
      idle(6'h2A, 8);
      idle(6'h15, 8);
      idle(6'h00, 8);

      // R3 and R6: sparse mask, gate open
      step(6'h00, 1'b1, 3'd2, 16'h0005);
      step(6'h00, 1'b1, 3'd4, 16'h0080);
      idle(6'h04, 8);
      idle(6'h24, 8);
      // R6: close with every other bit set, then reopen
      step(6'h24, 1'b1, 3'd4, 16'hFF7F);
      idle(6'h24, 8);                       // R8: gate status still set
      step(6'h20, 1'b1, 3'd2, 16'h0020);    // source drops as mask changes
      idle(6'h21, 8);
      step(6'h21, 1'b1, 3'd4, 16'h0080);
      idle(6'h3F, 8);

      // R4: partial then full clear
      step(6'h3F, 1'b1, 3'd3, 16'h0001);
      idle(6'h3F, 8);
      step(6'h3F, 1'b1, 3'd3, 16'hFFFF);
      idle(6'h3F, 8);

      // R5: nonexistent mask bits
      step(6'h3F, 1'b1, 3'd2, 16'hFFC0);
      idle(6'h3F, 8);

      // R10: writes to read-only addresses
      step(6'h3F, 1'b1, 3'd2, 16'h0012);
      step(6'h3F, 1'b1, 3'd0, 16'hFFFF);
      step(6'h3F, 1'b1, 3'd1, 16'h0000);
      step(6'h3F, 1'b1, 3'd5, 16'h0000);
      step(6'h3F, 1'b1, 3'd6, 16'hFFFF);
      step(6'h3F, 1'b1, 3'd7, 16'h0000);
      idle(6'h3F, 8);

      // R9: priority patterns with all sources enabled
      step(6'h00, 1'b1, 3'd2, 16'h003F);
      for (int p = 0; p < 64; p++) idle(6'(p), 8);

      // random phase
      for (int k = 0; k < 4000; k++) begin
         bit [2:0] wa = 3'($urandom_range(0, 7));
         bit [15:0] wd = 16'($urandom);
         step(6'($urandom), ($urandom_range(0, 3) == 0), wa, wd);
      end
      idle(6'h00, 8);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule